// File: doc/BRIEF.md
# Burst-Mode Video Line Timing Calculator

This block turns a horizontal video line description into the byte-clock budgets a serial display transmitter needs when it sends each line in a short burst and spends the rest of the line in a low-power state. The caller supplies the total line length, active width, back porch and sync width in pixels, plus the pixel depth and the number of active data lanes. One pulse on `start` latches the configuration. A single shared sequential divider then works out three round-up quotients, one quotient bit per clock. When the results are ready, `done` pulses.

The results are the line length in byte-clock cycles and the doubled byte budgets for the burst timing. These are the blank-line event packet size, the regular-line and vertical-blanking-line durations, the end-of-line blanking duration and the end-of-line blanking packet size. The block also drives constant mode flags: burst on, both sync-pulse modes off, and a zero front porch so that the transmitter uses blanking or low power at the end of each line.

`start` and `done` are plain control pins and not a stream. There is no back-pressure and no queue. A `start` seen while `busy` is high is dropped, so the caller must wait for `done` before launching the next configuration.

Top module: `burst_line_timing`

## Requirements
- R1: `burst_en` is always 1, `vsync_pulse_en` and `hsync_pulse_en` are always 0, and `hfp_bytes` is always 0.
- R2: A `start` while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, and `busy` is low on the cycle after `done`.
- R3: A `start` seen while `busy` is high is ignored. Input changes after the accepted `start` do not affect the results.
- R4: With line bytes LB = floor(hline_px × bpp / 8), `line_cycles` = ceil(LB / lanes).
- R5: `blank_evt_bytes` = 2 × LB − 4.
- R6: `reg_line_cycles` and `vblank_line_cycles` both equal 2 × `line_cycles` − ceil(4 / lanes).
- R7: `eol_blank_cycles` = 2 × `line_cycles` − ceil((hbp_px + hact_px) / lanes).
- R8: `eol_blank_bytes` = 2 × `line_cycles` − (hact_px + hbp_px + hsync_px).
- R9: `bpp` must be 16, 18 or 24, and `lanes` must be 1 to 4. Any other value sets `err` and forces all six result outputs to 0.
- R10: A subtraction that would go negative gives 0 for that output and sets `err`. Otherwise, for a legal configuration, `err` is 0.
- R11: The results and `err` change only in the cycle where `done` is high, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse; latches the configuration when idle |
| hline_px | input | PIX_W | Total line length in pixels |
| hact_px | input | PIX_W | Active width in pixels |
| hbp_px | input | PIX_W | Back porch in pixels |
| hsync_px | input | PIX_W | Sync width in pixels |
| bpp | input | 5 | Bits per pixel (16, 18 or 24) |
| lanes | input | 3 | Active lane count (1 to 4) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| err | output | 1 | Illegal configuration or saturated result |
| line_cycles | output | PIX_W+7 | Line length in byte-clock cycles |
| blank_evt_bytes | output | PIX_W+7 | Blank-line event packet size |
| reg_line_cycles | output | PIX_W+7 | Regular-line duration |
| vblank_line_cycles | output | PIX_W+7 | Vertical-blanking-line duration |
| eol_blank_cycles | output | PIX_W+7 | End-of-line blanking duration |
| eol_blank_bytes | output | PIX_W+7 | End-of-line blanking packet size |
| burst_en | output | 1 | Burst mode flag, constant 1 |
| vsync_pulse_en | output | 1 | Sync-pulse mode flag, constant 0 |
| hsync_pulse_en | output | 1 | Horizontal sync-pulse flag, constant 0 |
| hfp_bytes | output | PIX_W | Front porch on the serial side, constant 0 |

## Verification
The assertions check the handshake rules on every cycle: `done` lasts one cycle, `busy` rises after an accepted launch and stays high until `done`, and the results and `err` hold except on `done`. They also check that the regular-line and vertical-blanking durations always match, and that a zero line length always comes with `err`. Only the bench scenarios can show that the arithmetic is right. These scenarios compare against bench-computed expected values and cover round-up for every lane count, truncation of 18-bit pixel depths, saturation, rejected configurations, a `start` and input changes during a run, and inputs changed with no `start` after completion.

// File: rtl/burst_timing_pkg.sv
package burst_timing_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LD_LINE,
    ST_WT_LINE,
    ST_LD_HDR,
    ST_WT_HDR,
    ST_LD_ACT,
    ST_WT_ACT,
    ST_FIN,
    ST_DONE
  } calc_state_t;

  function automatic logic cfg_legal(input logic [4:0] depth, input logic [2:0] nl);
    logic depth_ok;
    logic lane_ok;
    depth_ok = (depth == 5'd16) || (depth == 5'd18) || (depth == 5'd24);
    lane_ok  = (nl >= 3'd1) && (nl <= 3'd4);
    return depth_ok && lane_ok;
  endfunction

endpackage

// File: rtl/ceil_div_seq.sv
module ceil_div_seq #(
  parameter int NUM_W = 21,
  parameter int DEN_W = 3,
  localparam int A_W   = NUM_W + 1,
  localparam int CNT_W = $clog2(A_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [A_W-1:0]   quo
);

  logic [A_W-1:0]   acc;
  logic [DEN_W-1:0] rem;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [DEN_W:0]   trial;

  assign trial = {rem, acc[A_W-1]};
  assign quo   = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      rem <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !run) begin
        // round up by pre-biasing the dividend with den-1
        acc <= A_W'(num) + A_W'(den) - A_W'(1);
        rem <= '0;
        cnt <= CNT_W'(A_W);
        run <= 1'b1;
      end else if (run) begin
        if (trial >= {1'b0, den}) begin
          rem <= DEN_W'(trial - {1'b0, den});
          acc <= {acc[A_W-2:0], 1'b1};
        end else begin
          rem <= trial[DEN_W-1:0];
          acc <= {acc[A_W-2:0], 1'b0};
        end
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sat_sub.sv
module sat_sub #(
  parameter int W = 23
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         neg
);

  always_comb begin
    neg = (a < b);
    y   = neg ? '0 : (a - b);
  end

endmodule

// File: rtl/burst_line_timing.sv
module burst_line_timing
  import burst_timing_pkg::*;
#(
  parameter int PIX_W = 16,
  localparam int DIV_W = PIX_W + 5,
  localparam int Q_W   = DIV_W + 1,
  localparam int OUT_W = Q_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PIX_W-1:0] hline_px,
  input  logic [PIX_W-1:0] hact_px,
  input  logic [PIX_W-1:0] hbp_px,
  input  logic [PIX_W-1:0] hsync_px,
  input  logic [4:0]       bpp,
  input  logic [2:0]       lanes,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [OUT_W-1:0] line_cycles,
  output logic [OUT_W-1:0] blank_evt_bytes,
  output logic [OUT_W-1:0] reg_line_cycles,
  output logic [OUT_W-1:0] vblank_line_cycles,
  output logic [OUT_W-1:0] eol_blank_cycles,
  output logic [OUT_W-1:0] eol_blank_bytes,
  output logic             burst_en,
  output logic             vsync_pulse_en,
  output logic             hsync_pulse_en,
  output logic [PIX_W-1:0] hfp_bytes
);

  calc_state_t state;

  logic [DIV_W-1:0] prod_q;
  logic [DIV_W-1:0] hab_q;
  logic [OUT_W-1:0] span_q;
  logic [2:0]       lanes_q;
  logic             bad_q;

  logic [Q_W-1:0]   tot_q;
  logic [Q_W-1:0]   hdr_q;
  logic [Q_W-1:0]   act_q;

  logic             div_go;
  logic [DIV_W-1:0] div_num;
  logic             div_fin;
  logic [Q_W-1:0]   div_quo;

  logic [DIV_W-1:0] lb_w;
  logic [OUT_W-1:0] two_lb, two_tot;
  logic [OUT_W-1:0] evt_y, dur_y, eolc_y, eolb_y;
  logic             evt_n, dur_n, eolc_n, eolb_n;

  assign burst_en       = 1'b1;
  assign vsync_pulse_en = 1'b0;
  assign hsync_pulse_en = 1'b0;
  assign hfp_bytes      = '0;

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  assign lb_w = prod_q >> 3;

  always_comb begin
    div_go  = (state == ST_LD_LINE) || (state == ST_LD_HDR) || (state == ST_LD_ACT);
    case (state)
      ST_LD_LINE: div_num = lb_w;
      ST_LD_ACT:  div_num = hab_q;
      default:    div_num = DIV_W'(4);
    endcase
  end

  ceil_div_seq #(.NUM_W(DIV_W), .DEN_W(3)) div_i (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .num  (div_num),
    .den  (lanes_q),
    .fin  (div_fin),
    .quo  (div_quo)
  );

  assign two_lb  = {{(OUT_W-DIV_W-1){1'b0}}, lb_w, 1'b0};
  assign two_tot = {tot_q, 1'b0};

  sat_sub #(.W(OUT_W)) sub_evt_i (
    .a(two_lb), .b(OUT_W'(4)), .y(evt_y), .neg(evt_n));
  sat_sub #(.W(OUT_W)) sub_dur_i (
    .a(two_tot), .b({1'b0, hdr_q}), .y(dur_y), .neg(dur_n));
  sat_sub #(.W(OUT_W)) sub_eolc_i (
    .a(two_tot), .b({1'b0, act_q}), .y(eolc_y), .neg(eolc_n));
  sat_sub #(.W(OUT_W)) sub_eolb_i (
    .a(two_tot), .b(span_q), .y(eolb_y), .neg(eolb_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      prod_q  <= '0;
      hab_q   <= '0;
      span_q  <= '0;
      lanes_q <= '0;
      bad_q   <= 1'b0;
      tot_q   <= '0;
      hdr_q   <= '0;
      act_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          prod_q  <= DIV_W'(hline_px) * DIV_W'(bpp);
          hab_q   <= DIV_W'(hact_px) + DIV_W'(hbp_px);
          span_q  <= OUT_W'(hact_px) + OUT_W'(hbp_px) + OUT_W'(hsync_px);
          lanes_q <= lanes;
          bad_q   <= !cfg_legal(bpp, lanes);
          state   <= cfg_legal(bpp, lanes) ? ST_LD_LINE : ST_FIN;
        end
        ST_LD_LINE: state <= ST_WT_LINE;
        ST_WT_LINE: if (div_fin) begin
          tot_q <= div_quo;
          state <= ST_LD_HDR;
        end
        ST_LD_HDR: state <= ST_WT_HDR;
        ST_WT_HDR: if (div_fin) begin
          hdr_q <= div_quo;
          state <= ST_LD_ACT;
        end
        ST_LD_ACT: state <= ST_WT_ACT;
        ST_WT_ACT: if (div_fin) begin
          act_q <= div_quo;
          state <= ST_FIN;
        end
        ST_FIN:  state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // results registered once, in the cycle that leads into done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err                <= 1'b0;
      line_cycles        <= '0;
      blank_evt_bytes    <= '0;
      reg_line_cycles    <= '0;
      vblank_line_cycles <= '0;
      eol_blank_cycles   <= '0;
      eol_blank_bytes    <= '0;
    end else if (state == ST_FIN) begin
      if (bad_q) begin
        err                <= 1'b1;
        line_cycles        <= '0;
        blank_evt_bytes    <= '0;
        reg_line_cycles    <= '0;
        vblank_line_cycles <= '0;
        eol_blank_cycles   <= '0;
        eol_blank_bytes    <= '0;
      end else begin
        err                <= evt_n | dur_n | eolc_n | eolb_n;
        line_cycles        <= {1'b0, tot_q};
        blank_evt_bytes    <= evt_y;
        reg_line_cycles    <= dur_y;
        vblank_line_cycles <= dur_y;
        eol_blank_cycles   <= eolc_y;
        eol_blank_bytes    <= eolb_y;
      end
    end
  end

endmodule

// File: rtl/burst_line_timing_chk.sv
module burst_line_timing_chk #(
  parameter int PIX_W = 16,
  localparam int OUT_W = PIX_W + 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [OUT_W-1:0] line_cycles,
  input logic [OUT_W-1:0] blank_evt_bytes,
  input logic [OUT_W-1:0] reg_line_cycles,
  input logic [OUT_W-1:0] vblank_line_cycles,
  input logic [OUT_W-1:0] eol_blank_cycles,
  input logic [OUT_W-1:0] eol_blank_bytes
);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(err) && $stable(line_cycles) && $stable(blank_evt_bytes)
               && $stable(reg_line_cycles) && $stable(vblank_line_cycles)
               && $stable(eol_blank_cycles) && $stable(eol_blank_bytes)));

  p_dur_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (reg_line_cycles == vblank_line_cycles));

  p_zero_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (line_cycles == '0)) |-> err);

endmodule

bind burst_line_timing burst_line_timing_chk #(.PIX_W(PIX_W)) chk_i (.*);

// File: tb/burst_line_timing_tb.sv
`timescale 1ns/1ps
module burst_line_timing_tb_top;

  localparam int PIX_W = 16;
  localparam int OUT_W = PIX_W + 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [PIX_W-1:0] hline_px = '0, hact_px = '0, hbp_px = '0, hsync_px = '0;
  logic [4:0]       bpp = 5'd24;
  logic [2:0]       lanes = 3'd4;
  logic             busy, done, err;
  logic [OUT_W-1:0] line_cycles, blank_evt_bytes, reg_line_cycles;
  logic [OUT_W-1:0] vblank_line_cycles, eol_blank_cycles, eol_blank_bytes;
  logic             burst_en, vsync_pulse_en, hsync_pulse_en;
  logic [PIX_W-1:0] hfp_bytes;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  burst_line_timing #(.PIX_W(PIX_W)) dut_i (.*);

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {
    longint tot, evt, dur, eolc, eolb;
    bit e;
  } exp_t;

  function automatic longint sat0(input longint v, inout bit e);
    if (v < 0) begin e = 1; return 0; end
    return v;
  endfunction

  function automatic exp_t model(input int hl, ha, hb, hs, bp, ln);
    exp_t r;
    longint lb;
    r.e = 0;
    if (!((bp == 16) || (bp == 18) || (bp == 24)) || ln < 1 || ln > 4) begin
      r.tot = 0; r.evt = 0; r.dur = 0; r.eolc = 0; r.eolb = 0; r.e = 1;
      return r;
    end
    lb    = (longint'(hl) * bp) / 8;
    r.tot = (lb + ln - 1) / ln;
    r.evt = sat0(2 * lb - 4, r.e);
    r.dur = sat0(2 * r.tot - (4 + ln - 1) / ln, r.e);
    r.eolc = sat0(2 * r.tot - (longint'(hb) + ha + ln - 1) / ln, r.e);
    r.eolb = sat0(2 * r.tot - (longint'(ha) + hb + hs), r.e);
    return r;
  endfunction

  exp_t last;

  task automatic compare(input exp_t x);
    check("R4 line_cycles", line_cycles, x.tot);
    check("R5 blank_evt_bytes", blank_evt_bytes, x.evt);
    check("R6 reg_line_cycles", reg_line_cycles, x.dur);
    check("R6 vblank_line_cycles", vblank_line_cycles, x.dur);
    check("R7 eol_blank_cycles", eol_blank_cycles, x.eolc);
    check("R8 eol_blank_bytes", eol_blank_bytes, x.eolb);
    check("R9 R10 err", err, x.e);
  endtask

  task automatic run_cfg(input int hl, ha, hb, hs, bp, ln, input bit disturb);
    exp_t x;
    int wait_n;
    x = model(hl, ha, hb, hs, bp, ln);
    @(negedge clk);
    hline_px = PIX_W'(hl); hact_px = PIX_W'(ha); hbp_px = PIX_W'(hb);
    hsync_px = PIX_W'(hs); bpp = 5'(bp); lanes = 3'(ln);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    if (disturb) begin
      // R3: new inputs and a second start while busy must change nothing
      hline_px = PIX_W'($urandom); hact_px = PIX_W'($urandom);
      hbp_px = PIX_W'($urandom); hsync_px = PIX_W'($urandom);
      bpp = 5'd16; lanes = 3'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    check("R2 done arrives", done, 1);
    compare(x);
    @(negedge clk);
    check("R2 done one cycle", done, 0);
    check("R2 busy low after done", busy, 0);
    if (disturb) check("R3 second start ignored", busy, 0);
    last = x;
  endtask

  initial begin
    int s;
    s = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    check("R11 reset line_cycles", line_cycles, 0);
    check("R11 reset err", err, 0);
    check("R2 reset busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 burst_en", burst_en, 1);
    check("R1 vsync_pulse_en", vsync_pulse_en, 0);
    check("R1 hsync_pulse_en", hsync_pulse_en, 0);
    check("R1 hfp_bytes", hfp_bytes, 0);

    // directed: reference line, every lane count, every depth
    run_cfg(2592, 1920, 30, 20, 24, 4, 0);
    for (int l = 1; l <= 4; l++) run_cfg(2592, 1920, 30, 20, 24, l, 0);
    run_cfg(1001, 640, 33, 7, 18, 3, 0);
    run_cfg(999, 500, 17, 5, 16, 2, 0);
    // R10 saturation and zero-length line
    run_cfg(4, 100, 10, 10, 16, 1, 0);
    run_cfg(0, 0, 0, 0, 24, 2, 0);
    // R9 illegal configurations
    run_cfg(2592, 1920, 30, 20, 20, 4, 0);
    run_cfg(2592, 1920, 30, 20, 24, 0, 0);
    run_cfg(2592, 1920, 30, 20, 24, 5, 0);
    // R3 start and input changes during a run
    run_cfg(2200, 1280, 40, 12, 24, 3, 1);
    // R11 inputs change with no start after completion
    hline_px = 16'd77; bpp = 5'd3; lanes = 3'd7;
    repeat (6) @(negedge clk);
    check("R11 no start no change", done, 0);
    compare(last);

    for (int i = 0; i < 40; i++) begin
      int hl, ha, hb, hs, bp, ln, pick;
      hl = int'($urandom % 8192);
      ha = int'($urandom % (hl + 1));
      hb = int'($urandom % 200);
      hs = int'($urandom % 100);
      pick = int'($urandom % 10);
      bp = (pick < 3) ? 16 : (pick < 6) ? 18 : (pick < 9) ? 24 : int'($urandom % 32);
      ln = ($urandom % 8 == 0) ? int'($urandom % 8) : int'(1 + $urandom % 4);
      run_cfg(hl, ha, hb, hs, bp, ln, (i % 7) == 3);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule